// File: doc/BRIEF.md
# Widening Multiply-Accumulate by Element

This block is the datapath for a widening integer multiply-accumulate in which one scalar element is broadcast across a vector. It takes three 128-bit vectors: a first source, a second source that supplies the broadcast element, and an accumulator. It picks the lower or upper 64-bit half of the first source and splits it into narrow lanes. Each lane is multiplied by the single element picked from the second source. Each product is twice the narrow width, and it is added to or subtracted from the matching double-width accumulator lane. The new 128-bit vector comes out as the result.

Two narrow widths are supported, 16-bit and 32-bit, and a two-bit size code selects between them. The other two size codes are reserved. For a reserved code the block raises an undefined-encoding flag and passes the accumulator through unchanged. The position of the broadcast element is given by three control bits, and how they are packed depends on the element size. A parameter chooses a combinational path or a single output register stage, where a valid bit follows the data with one cycle of latency.

Top module: `widen_mac_elem`

## Requirements
- R1: With size code 2'b01 the selected 64-bit half is four 16-bit lanes, lane i in bits [16i+15:16i]. result[32i+31:32i] equals acc_in[32i+31:32i] plus or minus the product of lane i and the broadcast element, taken modulo 2^32.
- R2: With size code 2'b10 the selected half is two 32-bit lanes, lane i in bits [32i+31:32i]. result[64i+63:64i] equals acc_in[64i+63:64i] plus or minus the product of lane i and the broadcast element, taken modulo 2^64.
- R3: With size code 2'b00 or 2'b11, undef_flag is 1 and result equals acc_in bit for bit. With size code 2'b01 or 2'b10, undef_flag is 0.
- R4: half_sel = 0 takes src_a[63:0] as the narrow operand, and half_sel = 1 takes src_a[127:64].
- R5: For 16-bit elements the broadcast index is k = {idx_h, idx_l, idx_m}, with idx_h as the most significant bit, and the element is src_b[16k+15:16k]. Indices 4 to 7 therefore reach the upper 64 bits of src_b.
- R6: For 32-bit elements the broadcast index is k = {idx_h, idx_l}, and the element is src_b[32k+31:32k]. idx_m has no effect on the result.
- R7: is_unsigned = 1 zero-extends both multiplicands, and is_unsigned = 0 sign-extends both (two's complement).
- R8: do_sub = 1 subtracts the product from the accumulator lane, and do_sub = 0 adds it. Either way the lane wraps modulo 2^(lane width), with no saturation.
- R9: With REG_OUT = 1, out_valid is in_valid delayed by one clock. result and undef_flag for an input accepted at one rising edge are visible after that same edge.
- R10: With REG_OUT = 1, result and undef_flag hold their values while in_valid is 0. An asynchronous active-low reset clears out_valid, result and undef_flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| size_code | input | 2 | Element size: 01 = 16-bit, 10 = 32-bit, others reserved |
| half_sel | input | 1 | Selects the lower (0) or upper (1) half of src_a |
| idx_h | input | 1 | Most significant index bit |
| idx_l | input | 1 | Middle index bit |
| idx_m | input | 1 | Least significant index bit (16-bit mode only) |
| is_unsigned | input | 1 | 1 = unsigned multiplicands, 0 = signed |
| do_sub | input | 1 | 1 = subtract the product, 0 = add it |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Vector holding the broadcast element |
| acc_in | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Accumulated vector |
| undef_flag | output | 1 | Reserved size code seen |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Indices 4 to 7 in 16-bit mode and indices 2 and 3 in 32-bit mode.** These live in the upper half of src_b. A decoder that dropped idx_h, or that used idx_m as the low index bit in 32-bit mode, would multiply by the wrong element.
- **All-ones lanes under signed and under unsigned mode.** Here the two interpretations give different products, so wrong sign extension shows up as a wrong high half.
- **An accumulator of all ones plus a product of one.** This must wrap to zero.
- **Reserved size codes.** These must leave the accumulator untouched; any leak of lane arithmetic would change the result.
- **Idle cycles and a reset in mid-stream.** These expose a register that loads while in_valid is low or that keeps stale data after reset.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

   localparam int unsigned NARROW_EW = 16;
   localparam int unsigned WIDE_EW   = 32;
   localparam int unsigned IDX_W     = 3;

   typedef enum logic [1:0] {
      SZ_RSV_LO = 2'b00,
      SZ_HALF16 = 2'b01,
      SZ_WORD32 = 2'b10,
      SZ_RSV_HI = 2'b11
   } wmac_size_e;

   typedef struct packed {
      logic             legal;
      logic             wide;
      logic [IDX_W-1:0] idx;
   } wmac_dec_t;

endpackage

// File: rtl/wmac_decode.sv
module wmac_decode
   import wmac_pkg::*;
(
   input  logic [1:0] size_code,
   input  logic       idx_h,
   input  logic       idx_l,
   input  logic       idx_m,
   output wmac_dec_t  dec
);

   always_comb begin
      dec = '0;
      unique case (wmac_size_e'(size_code))
         SZ_HALF16: begin
            dec.legal = 1'b1;
            dec.wide  = 1'b0;
            dec.idx   = {idx_h, idx_l, idx_m};
         end
         SZ_WORD32: begin
            dec.legal = 1'b1;
            dec.wide  = 1'b1;
            dec.idx   = {1'b0, idx_h, idx_l};
         end
         default: begin
            dec.legal = 1'b0;
            dec.wide  = 1'b0;
            dec.idx   = '0;
         end
      endcase
   end

endmodule

// File: rtl/wmac_elem_pick.sv
module wmac_elem_pick
   import wmac_pkg::*;
#(
   parameter int unsigned HALF_W = 64,
   localparam int unsigned VEC_W = 2 * HALF_W,
   localparam int unsigned N_E16 = VEC_W / NARROW_EW,
   localparam int unsigned N_E32 = VEC_W / WIDE_EW
) (
   input  logic [VEC_W-1:0]     src_a,
   input  logic [VEC_W-1:0]     src_b,
   input  logic                 half_sel,
   input  logic [IDX_W-1:0]     idx,
   output logic [HALF_W-1:0]    a_half,
   output logic [NARROW_EW-1:0] b_e16,
   output logic [WIDE_EW-1:0]   b_e32
);

   logic [NARROW_EW-1:0] e16_arr [N_E16];
   logic [WIDE_EW-1:0]   e32_arr [N_E32];

   for (genvar g = 0; g < N_E16; g++) begin : g_e16
      assign e16_arr[g] = src_b[g*NARROW_EW +: NARROW_EW];
   end

   for (genvar g = 0; g < N_E32; g++) begin : g_e32
      assign e32_arr[g] = src_b[g*WIDE_EW +: WIDE_EW];
   end

   assign a_half = half_sel ? src_a[VEC_W-1:HALF_W] : src_a[HALF_W-1:0];
   assign b_e16  = e16_arr[idx];
   assign b_e32  = e32_arr[idx[IDX_W-2:0]];

endmodule

// File: rtl/wmac_lane.sv
module wmac_lane #(
   parameter int unsigned EW = 16,
   localparam int unsigned RW = 2 * EW
) (
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   input  logic [RW-1:0] acc,
   input  logic          uns,
   input  logic          sub,
   output logic [RW-1:0] res
);

   logic [RW-1:0] a_ext;
   logic [RW-1:0] b_ext;
   logic [RW-1:0] prod;

   always_comb begin
      a_ext = uns ? {{EW{1'b0}}, a} : {{EW{a[EW-1]}}, a};
      b_ext = uns ? {{EW{1'b0}}, b} : {{EW{b[EW-1]}}, b};
      prod  = a_ext * b_ext;
      res   = sub ? (acc - prod) : (acc + prod);
   end

endmodule

// File: rtl/wmac_lane_array.sv
module wmac_lane_array #(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned EW     = 16,
   localparam int unsigned VEC_W = 2 * HALF_W,
   localparam int unsigned LANES = HALF_W / EW
) (
   input  logic [HALF_W-1:0] a_half,
   input  logic [EW-1:0]     b_elem,
   input  logic [VEC_W-1:0]  acc,
   input  logic              uns,
   input  logic              sub,
   output logic [VEC_W-1:0]  res
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      wmac_lane #(.EW(EW)) u_lane (
         .a   (a_half[g*EW +: EW]),
         .b   (b_elem),
         .acc (acc[g*2*EW +: 2*EW]),
         .uns (uns),
         .sub (sub),
         .res (res[g*2*EW +: 2*EW])
      );
   end

endmodule

// File: rtl/widen_mac_elem.sv
module widen_mac_elem
   import wmac_pkg::*;
#(
   parameter int unsigned HALF_W  = 64,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned VEC_W  = 2 * HALF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       size_code,
   input  logic             half_sel,
   input  logic             idx_h,
   input  logic             idx_l,
   input  logic             idx_m,
   input  logic             is_unsigned,
   input  logic             do_sub,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] acc_in,
   output logic             out_valid,
   output logic [VEC_W-1:0] result,
   output logic             undef_flag
);

   if (HALF_W != 4 * NARROW_EW) begin : g_bad_half
      $error("widen_mac_elem: HALF_W must hold four narrow elements");
   end
   if (HALF_W % WIDE_EW != 0) begin : g_bad_wide
      $error("widen_mac_elem: HALF_W must be a multiple of the wide element");
   end

   wmac_dec_t            dec;
   logic [HALF_W-1:0]    a_half;
   logic [NARROW_EW-1:0] b_e16;
   logic [WIDE_EW-1:0]   b_e32;
   logic [VEC_W-1:0]     res16;
   logic [VEC_W-1:0]     res32;
   logic [VEC_W-1:0]     res_nxt;
   logic                 undef_nxt;

   wmac_decode u_dec (
      .size_code (size_code),
      .idx_h     (idx_h),
      .idx_l     (idx_l),
      .idx_m     (idx_m),
      .dec       (dec)
   );

   wmac_elem_pick #(.HALF_W(HALF_W)) u_pick (
      .src_a    (src_a),
      .src_b    (src_b),
      .half_sel (half_sel),
      .idx      (dec.idx),
      .a_half   (a_half),
      .b_e16    (b_e16),
      .b_e32    (b_e32)
   );

   wmac_lane_array #(.HALF_W(HALF_W), .EW(NARROW_EW)) u_arr16 (
      .a_half (a_half),
      .b_elem (b_e16),
      .acc    (acc_in),
      .uns    (is_unsigned),
      .sub    (do_sub),
      .res    (res16)
   );

   wmac_lane_array #(.HALF_W(HALF_W), .EW(WIDE_EW)) u_arr32 (
      .a_half (a_half),
      .b_elem (b_e32),
      .acc    (acc_in),
      .uns    (is_unsigned),
      .sub    (do_sub),
      .res    (res32)
   );

   always_comb begin
      undef_nxt = ~dec.legal;
      if (!dec.legal) begin
         res_nxt = acc_in;
      end else if (dec.wide) begin
         res_nxt = res32;
      end else begin
         res_nxt = res16;
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            undef_flag <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result     <= res_nxt;
               undef_flag <= undef_nxt;
            end
         end
      end
   end else begin : g_comb_out
      assign out_valid  = in_valid;
      assign result     = res_nxt;
      assign undef_flag = undef_nxt;
   end

endmodule

// File: rtl/wmac_chk.sv
module wmac_chk #(
   parameter int unsigned VEC_W   = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       size_code,
   input logic [VEC_W-1:0] src_b,
   input logic [VEC_W-1:0] acc_in,
   input logic             out_valid,
   input logic [VEC_W-1:0] result,
   input logic             undef_flag
);

   logic legal_sz;
   assign legal_sz = (size_code == 2'b01) || (size_code == 2'b10);

   if (REG_OUT) begin : g_seq
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid) else $error("valid not forwarded"); // R9

      AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid) else $error("valid without input"); // R9

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(result) && $stable(undef_flag))) else $error("output moved while idle"); // R10

      AST_RSV_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !legal_sz) |=> (undef_flag && result == $past(acc_in))) else $error("reserved code altered acc"); // R3

      AST_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && legal_sz) |=> !undef_flag) else $error("flag on legal code"); // R3

      AST_ZERO_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && legal_sz && src_b == '0) |=> (result == $past(acc_in))) else $error("zero product changed acc"); // R8
   end else begin : g_comb
      always_comb begin
         if (rst_n) begin
            AST_RSV_PASSTHRU_C: assert (legal_sz || (undef_flag && result == acc_in)); // R3
            AST_LEGAL_NO_FLAG_C: assert (!legal_sz || !undef_flag); // R3
            AST_VALID_FOLLOWS_C: assert (out_valid == in_valid); // R9
            AST_ZERO_ELEM_C: assert (!legal_sz || src_b != '0 || result == acc_in); // R8
         end
      end
   end

endmodule

bind widen_mac_elem wmac_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .size_code  (size_code),
   .src_b      (src_b),
   .acc_in     (acc_in),
   .out_valid  (out_valid),
   .result     (result),
   .undef_flag (undef_flag)
);

// File: tb/widen_mac_elem_bench.sv
`timescale 1ns/100ps
module widen_mac_elem_bench;

   typedef struct packed {
      logic [1:0]   sz;
      logic         q;
      logic         h;
      logic         l;
      logic         m;
      logic         u;
      logic         s;
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] acc;
      logic [127:0] exp;
      logic         undef;
   } vec_t;

   localparam int N_TBL = 9;
   localparam vec_t TBL [N_TBL] = '{
      // R1 R4 R5: plain 16-bit lanes, index 0
      '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        128'hFFFF_FFFF_FFFF_FFFF_0004_0003_0002_0001,
        128'h0000_0000_0000_0000_0000_0000_0000_0003,
        128'h0,
        128'h0000000C_00000009_00000006_00000003, 1'b0},
      // R7: signed -1 * 2 + 10
      '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0000_0000_0000_0000_0002,
        128'h0000000A_0000000A_0000000A_0000000A,
        128'h00000008_00000008_00000008_00000008, 1'b0},
      // R7: unsigned 0xFFFF * 2 + 10
      '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
        128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0000_0000_0000_0000_0002,
        128'h0000000A_0000000A_0000000A_0000000A,
        128'h00020008_00020008_00020008_00020008, 1'b0},
      // R8: signed subtract 10 - (-2)
      '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
        128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0000_0000_0000_0000_0002,
        128'h0000000A_0000000A_0000000A_0000000A,
        128'h0000000C_0000000C_0000000C_0000000C, 1'b0},
      // R2 R4 R6: upper half, index 3, idx_m = 1
      '{2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
        128'h00000002_FFFFFFFF_55555555_55555555,
        128'h00000010_77777777_77777777_77777777,
        128'h0,
        128'h0000000000000020_FFFFFFFFFFFFFFF0, 1'b0},
      // R6: same with idx_m = 0, same result
      '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
        128'h00000002_FFFFFFFF_55555555_55555555,
        128'h00000010_77777777_77777777_77777777,
        128'h0,
        128'h0000000000000020_FFFFFFFFFFFFFFF0, 1'b0},
      // R3: reserved code 00
      '{2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
        128'hDEADBEEF_00010002_00030004_CAFEF00D,
        128'h11111111_22222222_33333333_44444444,
        128'h0123456789ABCDEF_FEDCBA9876543210,
        128'h0123456789ABCDEF_FEDCBA9876543210, 1'b1},
      // R8: wrap of all-ones accumulator plus one
      '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
        128'h0000_0000_0000_0000_0000_0001_0000_0001,
        128'h0000_0000_0000_0000_0000_0000_0000_0001,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0, 1'b0},
      // R5: index 7 reaches top 16 bits of src_b
      '{2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
        128'h0000_0000_0000_0000_0001_0001_0001_0001,
        128'h0005_0000_0000_0000_0000_0000_0000_0000,
        128'h0,
        128'h00000005_00000005_00000005_00000005, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   size_code = '0;
   logic         half_sel = 1'b0;
   logic         idx_h = 1'b0;
   logic         idx_l = 1'b0;
   logic         idx_m = 1'b0;
   logic         is_unsigned = 1'b0;
   logic         do_sub = 1'b0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [127:0] acc_in = '0;
   logic         out_valid;
   logic [127:0] result;
   logic         undef_flag;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   widen_mac_elem u_widen_mac_elem (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .size_code   (size_code),
      .half_sel    (half_sel),
      .idx_h       (idx_h),
      .idx_l       (idx_l),
      .idx_m       (idx_m),
      .is_unsigned (is_unsigned),
      .do_sub      (do_sub),
      .src_a       (src_a),
      .src_b       (src_b),
      .acc_in      (acc_in),
      .out_valid   (out_valid),
      .result      (result),
      .undef_flag  (undef_flag)
   );

   function automatic logic [127:0] model(input logic [1:0] sz, input logic q, h, l, m, u, s,
                                          input logic [127:0] a, b, acc);
      logic [127:0] r;
      logic [63:0]  half, x, y, p;
      logic [15:0]  e16;
      logic [31:0]  e32;
      int           k;
      r = acc;
      half = q ? a[127:64] : a[63:0];
      if (sz == 2'b01) begin
         k = {29'd0, h, l, m};
         e16 = b[k*16 +: 16];
         y = u ? {48'd0, e16} : {{48{e16[15]}}, e16};
         for (int e = 0; e < 4; e++) begin
            x = u ? {48'd0, half[e*16 +: 16]} : {{48{half[e*16+15]}}, half[e*16 +: 16]};
            p = x * y;
            r[e*32 +: 32] = s ? acc[e*32 +: 32] - p[31:0] : acc[e*32 +: 32] + p[31:0];
         end
      end else if (sz == 2'b10) begin
         k = {30'd0, h, l};
         e32 = b[k*32 +: 32];
         y = u ? {32'd0, e32} : {{32{e32[31]}}, e32};
         for (int e = 0; e < 2; e++) begin
            x = u ? {32'd0, half[e*32 +: 32]} : {{32{half[e*32+31]}}, half[e*32 +: 32]};
            p = x * y;
            r[e*64 +: 64] = s ? acc[e*64 +: 64] - p : acc[e*64 +: 64] + p;
         end
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] sz, input logic q, h, l, m, u, s,
                        input logic [127:0] a, b, acc);
      @(negedge clk);
      size_code = sz; half_sel = q; idx_h = h; idx_l = l; idx_m = m;
      is_unsigned = u; do_sub = s; src_a = a; src_b = b; acc_in = acc;
      in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_one(input string tag, input logic [1:0] sz, input logic q, h, l, m, u, s,
                          input logic [127:0] a, b, acc, exp, input logic undef_exp);
      apply(sz, q, h, l, m, u, s, a, b, acc);
      chk({tag, " R9 out_valid"}, {127'd0, out_valid}, 128'd1);
      chk({tag, " result"}, result, exp);
      chk({tag, " R3 undef_flag"}, {127'd0, undef_flag}, {127'd0, undef_exp});
      in_valid = 1'b0;
   endtask

   initial begin
      logic [1:0]   sz;
      logic [127:0] ra, rb, racc, rexp;
      logic         rh, rl, rm;
      string        tag;

      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", {127'd0, out_valid}, 128'd0);
      chk("R10 reset result", result, 128'd0);
      chk("R10 reset undef_flag", {127'd0, undef_flag}, 128'd0);
      rst_n = 1'b1;

      // table walk, with model cross-check of each row
      for (int i = 0; i < N_TBL; i++) begin
         chk($sformatf("R1 R2 model row %0d", i),
             model(TBL[i].sz, TBL[i].q, TBL[i].h, TBL[i].l, TBL[i].m, TBL[i].u, TBL[i].s,
                   TBL[i].a, TBL[i].b, TBL[i].acc), TBL[i].exp);
         run_one($sformatf("R1 R2 R4 R5 R6 R7 R8 row %0d", i), TBL[i].sz, TBL[i].q, TBL[i].h,
                 TBL[i].l, TBL[i].m, TBL[i].u, TBL[i].s, TBL[i].a, TBL[i].b, TBL[i].acc,
                 TBL[i].exp, TBL[i].undef);
      end

      // random sweep over size, half, signedness and subtract
      for (int i = 0; i < 256; i++) begin
         sz = i[1:0];
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         racc = {$urandom, $urandom, $urandom, $urandom};
         rh = $urandom; rl = $urandom; rm = $urandom;
         rexp = model(sz, i[2], rh, rl, rm, i[3], i[4], ra, rb, racc);
         tag = (sz == 2'b01) ? "R1 R7 R8 rand" : (sz == 2'b10) ? "R2 R7 R8 rand" : "R3 rand";
         run_one($sformatf("%s %0d", tag, i), sz, i[2], rh, rl, rm, i[3], i[4], ra, rb, racc,
                 rexp, (sz == 2'b00) || (sz == 2'b11));
      end

      // R10: idle cycle with new data must not move the outputs
      run_one("R10 pre-idle", TBL[0].sz, TBL[0].q, TBL[0].h, TBL[0].l, TBL[0].m, TBL[0].u,
              TBL[0].s, TBL[0].a, TBL[0].b, TBL[0].acc, TBL[0].exp, 1'b0);
      size_code = 2'b11; src_a = '1; src_b = '1; acc_in = 128'h5A5A;
      @(negedge clk);
      chk("R10 idle hold result", result, TBL[0].exp);
      chk("R10 idle hold undef_flag", {127'd0, undef_flag}, 128'd0);
      chk("R9 idle out_valid low", {127'd0, out_valid}, 128'd0);

      // R10: reset in mid-stream clears outputs
      run_one("R10 pre-reset", TBL[4].sz, TBL[4].q, TBL[4].h, TBL[4].l, TBL[4].m, TBL[4].u,
              TBL[4].s, TBL[4].a, TBL[4].b, TBL[4].acc, TBL[4].exp, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 mid reset result", result, 128'd0);
      chk("R10 mid reset out_valid", {127'd0, out_valid}, 128'd0);
      rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule